// File: doc/BRIEF.md
# Input Change Detection Interrupt

This block watches a bank of general-purpose input ports and raises an interrupt when any port set as an input no longer matches a stored reference level. The ports are organised in groups of eight. Each group keeps its own reference copy, called the snapshot. A host loads the snapshot again whenever it reads that group. A write to the configuration register loads it for every group.

The comparison runs all the time and is purely combinational from the stored snapshot. If a changed pin goes back to its stored level, the interrupt goes away without any host action. The interrupt flag is always available as a status bit. The pad drive output pulls low only when the interrupt is enabled and the flag is set; otherwise the pad is left released (high impedance). Pin levels come into the block already synchronised. The block also returns the live pin levels of each group as read data.

Top module: `chg_irq_monitor`

## Requirements
- R1: A one-cycle `cfg_wr` pulse makes every group's snapshot equal to that cycle's pin levels from the next cycle on. With the pins unchanged, the flag is then low.
- R2: A pulse on `snap_stb[g]` loads group g (bits 8g+7..8g) from that cycle's pins. The group stops contributing to the flag from the next cycle on.
- R3: A port takes part in the compare only while its `dir_in` bit is 1 (input). A mismatch on a port whose bit is 0 (output) never sets the flag.
- R4: The flag clears with no strobe once every mismatching input pin goes back to its snapshot level.
- R5: `irq_flag` shows the detected change whatever `irq_en` is. `irq_pin_low` is 1 (pull low) only when `irq_en` and `irq_flag` are both 1; otherwise it is 0 (released).
- R6: A strobe on one group leaves the other group's snapshot, and that group's share of the flag, unchanged.
- R7: The flag is held low during reset and for the first cycle after it. In that first cycle every snapshot is loaded from the pins, so static pins cause no interrupt.
- R8: Switching a port from output to input raises the flag when the port's level differs from the stored snapshot.
- R9: If a strobe and a pin change fall in the same cycle, the strobe wins: the snapshot takes the new level, and the flag is low in the following cycle.
- R10: `rd_data` always equals the live pin levels, whatever each port's direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | 16 | Synchronised pin levels, group g in bits 8g+7..8g |
| dir_in | input | 16 | Per-port direction, 1 = input, 0 = output |
| snap_stb | input | 2 | Per-group snapshot load (group register read) |
| cfg_wr | input | 1 | Configuration write, loads all snapshots |
| irq_en | input | 1 | Interrupt pin enable |
| irq_flag | output | 1 | Change-detected status |
| irq_pin_low | output | 1 | Pad pull-low enable for the interrupt pin |
| rd_data | output | 16 | Live pin levels returned on group reads |

## Verification
The assertions assume that `pin_lvl` is already synchronised and changes only between clock edges. They also assume that strobes are single-cycle pulses taken at the clock. The bench drives every input on the falling edge and samples one nanosecond later. The combinational flag is therefore checked against the snapshot stored at the previous rising edge, and a strobe takes effect only at the next edge. The vectors form one ordered sequence, so each row's expected value follows from the snapshot left by the rows before it.

// File: rtl/chg_irq_monitor.sv
module chg_irq_monitor #(
  parameter int GROUPS = 2,
  parameter int GW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [GROUPS*GW-1:0] pin_lvl,
  input  logic [GROUPS*GW-1:0] dir_in,
  input  logic [GROUPS-1:0]    snap_stb,
  input  logic                 cfg_wr,
  input  logic                 irq_en,
  output logic                 irq_flag,
  output logic                 irq_pin_low,
  output logic [GROUPS*GW-1:0] rd_data
);
  localparam int NP = GROUPS * GW;

  logic [NP-1:0]     snap_q;
  logic              init_q;
  logic [GROUPS-1:0] grp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b1;
      snap_q <= '0;
    end else begin
      init_q <= 1'b0;
      for (int g = 0; g < GROUPS; g++)
        if (init_q || cfg_wr || snap_stb[g])
          snap_q[g*GW +: GW] <= pin_lvl[g*GW +: GW];
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grp_hit[g] = |((snap_q[g*GW +: GW] ^ pin_lvl[g*GW +: GW]) & dir_in[g*GW +: GW]);

    a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_stb[g] || cfg_wr) |=> ($stable(pin_lvl[g*GW +: GW]) -> !grp_hit[g]));
  end

  assign irq_flag    = ~init_q & (|grp_hit);
  assign irq_pin_low = irq_en & irq_flag;
  assign rd_data     = pin_lvl;

  a_r3_outputs_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_in == '0) |-> !irq_flag);

  a_r5_pin_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pin_low |-> (irq_flag && irq_en));

  a_r7_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |=> ($stable(pin_lvl) -> !irq_flag));

  a_r4_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(init_q) && $stable(pin_lvl) && $stable(dir_in) &&
     ($past(snap_stb) == '0) && !$past(cfg_wr)) |-> $stable(irq_flag));
endmodule

// File: tb/tb_chg_irq_monitor.sv
module tb_chg_irq_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin_lvl = 16'h00F0;
  logic [15:0] dir_in = 16'hFFFF;
  logic [1:0]  snap_stb = 2'b00;
  logic        cfg_wr = 1'b0;
  logic        irq_en = 1'b1;
  logic        irq_flag, irq_pin_low;
  logic [15:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  chg_irq_monitor dut (.clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .dir_in(dir_in),
    .snap_stb(snap_stb), .cfg_wr(cfg_wr), .irq_en(irq_en), .irq_flag(irq_flag),
    .irq_pin_low(irq_pin_low), .rd_data(rd_data));

  always #2 clk = ~clk;

  // {pin, dir, stb, cfg, en, exp_flag, exp_low}
  localparam int NV = 18;
  localparam logic [37:0] VEC [NV] = '{
    {16'h00F0, 16'hFFFF, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0},
    {16'h00F1, 16'hFFFF, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1},
    {16'h00F0, 16'hFFFF, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0},
    {16'h00F1, 16'hFFFF, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h00F1, 16'hFFFF, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1},
    {16'h00F1, 16'hFFFF, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0},
    {16'h01F1, 16'hFFFF, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1},
    {16'h01F1, 16'hFFFF, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1},
    {16'h01F1, 16'hFFFF, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1},
    {16'h01F1, 16'hFFFF, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1},
    {16'h01F1, 16'hFFFF, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0},
    {16'h03F1, 16'hFDFF, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0},
    {16'h03F1, 16'hFFFF, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1},
    {16'h03F1, 16'hFFFF, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1},
    {16'h03F1, 16'hFFFF, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0},
    {16'h03F3, 16'hFFFF, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1},
    {16'h03F3, 16'hFFFF, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0},
    {16'h0000, 16'h0000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0}
  };
  string tag [NV] = '{"R7", "R3", "R4", "R5", "R5", "R2", "R3", "R6", "R6", "R6",
                      "R2", "R3", "R8", "R1", "R1", "R9", "R9", "R3"};

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R7", "flag in reset", 32'(irq_flag), 0);
    chk("R7", "pin in reset", 32'(irq_pin_low), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R7", "flag first cycle", 32'(irq_flag), 0);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {pin_lvl, dir_in, snap_stb, cfg_wr, irq_en} = VEC[i][37:2];
      #1;
      chk(tag[i], $sformatf("row %0d flag", i), 32'(irq_flag), 32'(VEC[i][1]));
      chk(tag[i], $sformatf("row %0d pin", i), 32'(irq_pin_low), 32'(VEC[i][0]));
      chk("R10", $sformatf("row %0d rd_data", i), 32'(rd_data), 32'(VEC[i][37:22]));
    end
    @(negedge clk);
    snap_stb = 2'b00; cfg_wr = 1'b0; dir_in = 16'hFFFF;
    // directed: reset with unusual static levels, then a group-1 change
    rst_n = 1'b0; pin_lvl = 16'h5A3C;
    #1 chk("R7", "flag reset again", 32'(irq_flag), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R7", "static pins no irq", 32'(irq_flag), 0);
    @(negedge clk);
    pin_lvl = 16'hDA3C;
    #1 chk("R3", "bit 15 change", 32'(irq_flag), 1);
    chk("R5", "pin pulls low", 32'(irq_pin_low), 1);
    @(negedge clk);
    pin_lvl = 16'h5A3C;
    #1 chk("R4", "bit 15 back", 32'(irq_flag), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule